// File: doc/BRIEF.md
# Binary-Field Montgomery Ladder Scalar Multiplier

This block multiplies a point P on an elliptic curve over GF(2^m) by an L-bit scalar k. It works x-only in projective (X, Z) coordinates and uses the Montgomery ladder. The caller supplies the affine x of P, the curve constant b and the scalar, and then pulses `start`. The block returns two projective ladder points. The first pair holds kP and the second holds (k+1)P. The affine x of kP is X1/Z1, and the caller does that division outside this block.

All field work goes through one bit-serial multiplier that handles a single operand pair at a time. Squaring is a multiply of a value by itself, and field addition is XOR. A micro-sequencer issues the same eleven operations for every scalar bit. The bit only selects which point is doubled and which register pair receives the sum, so the latency does not depend on the scalar.

Top module: `ecl_ladder_mult`

## Requirements
- R1: After reset, `done` is 0 and all four point outputs are 0.
- R2: On an accepted start, the ladder begins from (x, 1) and (x^4 + b, x^2). It then performs exactly L-1 iterations, one for each scalar bit from bit L-2 down to bit 0.
- R3: For an iteration whose scalar bit is 1, (X1,Z1) takes the sum of the two points and (X2,Z2) takes the double of (X2,Z2).
- R4: For an iteration whose scalar bit is 0, (X2,Z2) takes the sum of the two points and (X1,Z1) takes the double of (X1,Z1).
- R5: The sum is computed as Z = (X1·Z2 + X2·Z1)^2 and X = x·Z + (X1·Z2)·(X2·Z1).
- R6: The double of (X,Z) is computed as Z' = X^2·Z^2 and X' = X^4 + b·Z^4.
- R7: Field addition is XOR. Products are reduced modulo x^M + the tap polynomial `FB_TAPS`, where bit i of `FB_TAPS` is the coefficient of x^i.
- R8: The number of cycles from an accepted start to `done` is the same for every scalar.
- R9: A start that arrives while a computation is running is ignored, and the running computation finishes with its own operands.
- R10: `done` is high for exactly one cycle. The outputs then stay unchanged until the next accepted start.
- R11: Scalar bit L-1 is treated as 1 whatever its value, so the scalars k and k with its top bit set give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (taken only when idle) |
| x_in | input | M | Affine x of the base point |
| b_in | input | M | Curve constant b |
| k_in | input | L | Scalar |
| done | output | 1 | One-cycle completion pulse |
| x1_out | output | M | Projective X of kP |
| z1_out | output | M | Projective Z of kP |
| x2_out | output | M | Projective X of (k+1)P |
| z2_out | output | M | Projective Z of (k+1)P |

## Verification
Scalars with all lower bits 0 drive only the bit-0 routing, so they isolate repeated doubling of the first point. Scalars with all lower bits 1 do the same for the bit-1 routing. Mixed and pseudo-random scalars, checked over several base points and curve constants, expose wrong operand routing or a faulty sum or double formula, because the results are compared with an independent LSB-first field model. Scalars that differ only in the top bit must give equal results, and the latency measured for several scalars must be identical. A second start raised in the middle of a run must leave that run's results unchanged.

// File: rtl/ecl_pkg.sv
package ecl_pkg;
  // one entry per multiplier operation; order is the issue order
  typedef enum logic [3:0] {
    SP_T1     = 4'd0,   // X1*Z2
    SP_T2     = 4'd1,   // X2*Z1
    SP_SZ     = 4'd2,   // (T1+T2)^2
    SP_T3     = 4'd3,   // T1*T2
    SP_SX     = 4'd4,   // x*SZ + T3
    SP_T4     = 4'd5,   // Xd^2
    SP_T5     = 4'd6,   // Zd^2
    SP_DZ     = 4'd7,   // T4*T5
    SP_T6     = 4'd8,   // T5^2
    SP_BT     = 4'd9,   // b*T6
    SP_DX     = 4'd10,  // T4^2 + b*T6
    SP_INIT_Z = 4'd11,  // x^2
    SP_INIT_X = 4'd12   // (x^2)^2 + b
  } step_e;

  typedef enum logic [1:0] {
    CS_IDLE, CS_ISSUE, CS_WAIT, CS_COMMIT
  } ctrl_e;
endpackage

// File: rtl/ecl_gf_mul.sv
module ecl_gf_mul #(
  parameter int unsigned M = 163,
  parameter logic [M-1:0] FB_TAPS = M'(8'hC9)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic [M-1:0] prod,
  output logic         busy,
  output logic         fin
);
  localparam int unsigned CW = (M > 1) ? $clog2(M) : 1;

  // multiply by x modulo the field polynomial
  function automatic logic [M-1:0] mul_x(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? FB_TAPS : '0);
  endfunction

  logic [M-1:0]  a_q, b_q, acc_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; acc_q <= '0;
      cnt_q <= '0; busy <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        a_q   <= op_a;
        b_q   <= op_b;
        acc_q <= '0;
        cnt_q <= CW'(M - 1);
        busy  <= 1'b1;
      end else if (busy) begin
        acc_q <= mul_x(acc_q) ^ (b_q[M-1] ? a_q : '0);
        b_q   <= {b_q[M-2:0], 1'b0};
        if (cnt_q == '0) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign prod = acc_q;
endmodule

// File: rtl/ecl_ladder_ctrl.sv
module ecl_ladder_ctrl
  import ecl_pkg::*;
#(
  parameter int unsigned L = 163
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [L-1:0] k_in,
  input  logic         mul_fin,
  output step_e        step,
  output logic         cur_bit,
  output logic         load,
  output logic         mul_go,
  output logic         wr_en,
  output logic         commit,
  output logic         busy,
  output logic         done
);
  localparam int unsigned IW = (L > 1) ? $clog2(L) : 1;

  ctrl_e         st_q;
  step_e         step_q;
  logic [L-1:0]  k_q;
  logic [IW-1:0] idx_q;

  assign busy    = (st_q != CS_IDLE);
  assign load    = start && !busy;
  assign mul_go  = (st_q == CS_ISSUE);
  assign wr_en   = (st_q == CS_WAIT) && mul_fin;
  assign commit  = (st_q == CS_COMMIT);
  assign step    = step_q;
  assign cur_bit = k_q[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CS_IDLE; step_q <= SP_INIT_Z;
      k_q <= '0; idx_q <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        CS_IDLE: if (start) begin
          k_q    <= k_in;
          idx_q  <= IW'(L - 2);
          step_q <= SP_INIT_Z;
          st_q   <= CS_ISSUE;
        end
        CS_ISSUE: st_q <= CS_WAIT;
        CS_WAIT: if (mul_fin) begin
          if (step_q == SP_INIT_X) begin
            step_q <= SP_T1;
            st_q   <= CS_ISSUE;
          end else if (step_q == SP_DX) begin
            st_q <= CS_COMMIT;
          end else begin
            step_q <= step_e'(step_q + 4'd1);
            st_q   <= CS_ISSUE;
          end
        end
        CS_COMMIT: begin
          step_q <= SP_T1;
          if (idx_q == '0) begin
            st_q <= CS_IDLE;
            done <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
            st_q  <= CS_ISSUE;
          end
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecl_ladder_regs.sv
module ecl_ladder_regs
  import ecl_pkg::*;
#(
  parameter int unsigned M = 163
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [M-1:0] x_in,
  input  logic [M-1:0] b_in,
  input  step_e        step,
  input  logic         cur_bit,
  input  logic         wr_en,
  input  logic         commit,
  input  logic [M-1:0] prod,
  output logic [M-1:0] op_a,
  output logic [M-1:0] op_b,
  output logic [M-1:0] x1,
  output logic [M-1:0] z1,
  output logic [M-1:0] x2,
  output logic [M-1:0] z2
);
  logic [M-1:0] bx_q, bc_q;
  logic [M-1:0] t1_q, t2_q, t3_q, t4_q, t5_q, t6_q;
  logic [M-1:0] sx_q, sz_q, dx_q, dz_q;
  logic [M-1:0] xd, zd;

  // the point being doubled follows the scalar bit
  assign xd = cur_bit ? x2 : x1;
  assign zd = cur_bit ? z2 : z1;

  always_comb begin
    op_a = '0;
    op_b = '0;
    unique case (step)
      SP_INIT_Z: begin op_a = bx_q;        op_b = bx_q;        end
      SP_INIT_X: begin op_a = z2;          op_b = z2;          end
      SP_T1:     begin op_a = x1;          op_b = z2;          end
      SP_T2:     begin op_a = x2;          op_b = z1;          end
      SP_SZ:     begin op_a = t1_q ^ t2_q; op_b = t1_q ^ t2_q; end
      SP_T3:     begin op_a = t1_q;        op_b = t2_q;        end
      SP_SX:     begin op_a = bx_q;        op_b = sz_q;        end
      SP_T4:     begin op_a = xd;          op_b = xd;          end
      SP_T5:     begin op_a = zd;          op_b = zd;          end
      SP_DZ:     begin op_a = t4_q;        op_b = t5_q;        end
      SP_T6:     begin op_a = t5_q;        op_b = t5_q;        end
      SP_BT:     begin op_a = bc_q;        op_b = t6_q;        end
      SP_DX:     begin op_a = t4_q;        op_b = t4_q;        end
      default:   begin op_a = '0;          op_b = '0;          end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q <= '0; bc_q <= '0;
      x1 <= '0; z1 <= '0; x2 <= '0; z2 <= '0;
      t1_q <= '0; t2_q <= '0; t3_q <= '0; t4_q <= '0; t5_q <= '0; t6_q <= '0;
      sx_q <= '0; sz_q <= '0; dx_q <= '0; dz_q <= '0;
    end else if (load) begin
      bx_q <= x_in;
      bc_q <= b_in;
      x1   <= x_in;
      z1   <= M'(1);
    end else if (commit) begin
      if (cur_bit) begin
        x1 <= sx_q; z1 <= sz_q; x2 <= dx_q; z2 <= dz_q;
      end else begin
        x2 <= sx_q; z2 <= sz_q; x1 <= dx_q; z1 <= dz_q;
      end
    end else if (wr_en) begin
      unique case (step)
        SP_INIT_Z: z2   <= prod;
        SP_INIT_X: x2   <= prod ^ bc_q;
        SP_T1:     t1_q <= prod;
        SP_T2:     t2_q <= prod;
        SP_SZ:     sz_q <= prod;
        SP_T3:     t3_q <= prod;
        SP_SX:     sx_q <= prod ^ t3_q;
        SP_T4:     t4_q <= prod;
        SP_T5:     t5_q <= prod;
        SP_DZ:     dz_q <= prod;
        SP_T6:     t6_q <= prod;
        SP_BT:     t6_q <= prod;
        SP_DX:     dx_q <= prod ^ t6_q;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/ecl_ladder_mult.sv
module ecl_ladder_mult
  import ecl_pkg::*;
#(
  parameter int unsigned M = 163,
  parameter int unsigned L = 163,
  parameter logic [M-1:0] FB_TAPS = M'(8'hC9)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] x_in,
  input  logic [M-1:0] b_in,
  input  logic [L-1:0] k_in,
  output logic         done,
  output logic [M-1:0] x1_out,
  output logic [M-1:0] z1_out,
  output logic [M-1:0] x2_out,
  output logic [M-1:0] z2_out
);
  step_e        step;
  logic         cur_bit, load, mul_go, wr_en, commit, busy;
  logic         mul_busy, mul_fin;
  logic [M-1:0] op_a, op_b, prod;

  ecl_ladder_ctrl #(.L(L)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .k_in(k_in), .mul_fin(mul_fin),
    .step(step), .cur_bit(cur_bit), .load(load), .mul_go(mul_go),
    .wr_en(wr_en), .commit(commit), .busy(busy), .done(done)
  );

  ecl_ladder_regs #(.M(M)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(load), .x_in(x_in), .b_in(b_in),
    .step(step), .cur_bit(cur_bit), .wr_en(wr_en), .commit(commit),
    .prod(prod), .op_a(op_a), .op_b(op_b),
    .x1(x1_out), .z1(z1_out), .x2(x2_out), .z2(z2_out)
  );

  ecl_gf_mul #(.M(M), .FB_TAPS(FB_TAPS)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go), .op_a(op_a), .op_b(op_b),
    .prod(prod), .busy(mul_busy), .fin(mul_fin)
  );
endmodule

// File: rtl/ecl_ladder_chk.sv
module ecl_ladder_chk #(
  parameter int unsigned M = 163
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         commit,
  input logic         mul_go,
  input logic         mul_busy,
  input logic [M-1:0] x1_out,
  input logic [M-1:0] z1_out,
  input logic [M-1:0] x2_out,
  input logic [M-1:0] z2_out
);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(x1_out) && $stable(z1_out) &&
                           $stable(x2_out) && $stable(z2_out)));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !commit) |=> busy);

  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(commit));

  assert_mul_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |-> !mul_busy);

  assert_mul_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |=> mul_busy);
endmodule

bind ecl_ladder_mult ecl_ladder_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .commit(commit), .mul_go(mul_go), .mul_busy(mul_busy),
  .x1_out(x1_out), .z1_out(z1_out), .x2_out(x2_out), .z2_out(z2_out)
);

// File: tb/ecl_ladder_mult_bench.sv
module ecl_ladder_mult_bench;
  localparam int BM = 7;
  localparam int BL = 8;
  localparam logic [BM-1:0] BFB = 7'h03;   // x^7 + x + 1

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [BM-1:0] x_in = '0, b_in = '0;
  logic [BL-1:0] k_in = '0;
  logic done;
  logic [BM-1:0] x1_out, z1_out, x2_out, z2_out;

  int checks = 0, failures = 0;
  int last_lat = 0;

  always #10 clk = ~clk;

  ecl_ladder_mult #(.M(BM), .L(BL), .FB_TAPS(BFB)) u_ecl_ladder_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .b_in(b_in),
    .k_in(k_in), .done(done), .x1_out(x1_out), .z1_out(z1_out),
    .x2_out(x2_out), .z2_out(z2_out)
  );

  // LSB-first field product, written independently of the RTL
  function automatic logic [BM-1:0] fm(input logic [BM-1:0] a, input logic [BM-1:0] b);
    logic [BM-1:0] r = '0, s = a;
    for (int i = 0; i < BM; i++) begin
      if (b[i]) r = r ^ s;
      s = s[BM-1] ? ({s[BM-2:0], 1'b0} ^ BFB) : {s[BM-2:0], 1'b0};
    end
    return r;
  endfunction

  // reference ladder: pt[0]=(X1,Z1), pt[1]=(X2,Z2); bit selects doubled entry
  task automatic ref_ladder(input logic [BM-1:0] x, input logic [BM-1:0] b,
                            input logic [BL-1:0] k, output logic [BM-1:0] r [4]);
    logic [BM-1:0] px [2], pz [2];
    logic [BM-1:0] u, v, sz, sx, dz, dx, z2v;
    px[0] = x; pz[0] = 1;
    pz[1] = fm(x, x);
    px[1] = fm(pz[1], pz[1]) ^ b;
    for (int i = BL - 2; i >= 0; i--) begin
      int d = k[i] ? 1 : 0;
      u  = fm(px[0], pz[1]);
      v  = fm(px[1], pz[0]);
      sz = fm(u ^ v, u ^ v);
      sx = fm(x, sz) ^ fm(u, v);
      z2v = fm(pz[d], pz[d]);
      dz = fm(fm(px[d], px[d]), z2v);
      dx = fm(fm(px[d], px[d]), fm(px[d], px[d])) ^ fm(b, fm(z2v, z2v));
      px[d] = dx; pz[d] = dz;
      px[1-d] = sx; pz[1-d] = sz;
    end
    r[0] = px[0]; r[1] = pz[0]; r[2] = px[1]; r[3] = pz[1];
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start a run, wait for done (watchdog bounded), return latency
  task automatic run(input logic [BM-1:0] x, input logic [BM-1:0] b,
                     input logic [BL-1:0] k, output int lat);
    @(negedge clk);
    x_in = x; b_in = b; k_in = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    if (!done) chk("watchdog", 32'd0, 32'd1);
  endtask

  task automatic cmp_pts(input string req, input logic [BM-1:0] x,
                         input logic [BM-1:0] b, input logic [BL-1:0] k);
    logic [BM-1:0] e [4];
    ref_ladder(x, b, k, e);
    chk({req, " X1"}, 32'(x1_out), 32'(e[0]));
    chk({req, " Z1"}, 32'(z1_out), 32'(e[1]));
    chk({req, " X2"}, 32'(x2_out), 32'(e[2]));
    chk({req, " Z2"}, 32'(z2_out), 32'(e[3]));
  endtask

  task automatic t_reset();
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 X1", 32'(x1_out), 32'd0);
    chk("R1 Z1", 32'(z1_out), 32'd0);
    chk("R1 X2", 32'(x2_out), 32'd0);
    chk("R1 Z2", 32'(z2_out), 32'd0);
  endtask

  task automatic t_scalar(input string req, input logic [BM-1:0] x,
                          input logic [BM-1:0] b, input logic [BL-1:0] k);
    int lat;
    run(x, b, k, lat);
    cmp_pts(req, x, b, k);
    if (last_lat != 0) chk("R8 latency", 32'(lat), 32'(last_lat));
    last_lat = lat;
  endtask

  task automatic t_top_bit();
    logic [BM-1:0] a [4];
    int lat;
    run(7'h2B, 7'h11, 8'h35, lat);
    a[0] = x1_out; a[1] = z1_out; a[2] = x2_out; a[3] = z2_out;
    run(7'h2B, 7'h11, 8'hB5, lat);
    chk("R11 X1", 32'(x1_out), 32'(a[0]));
    chk("R11 Z1", 32'(z1_out), 32'(a[1]));
    chk("R11 X2", 32'(x2_out), 32'(a[2]));
    chk("R11 Z2", 32'(z2_out), 32'(a[3]));
    chk("R8 latency top", 32'(lat), 32'(last_lat));
  endtask

  task automatic t_busy_start();
    int n = 0;
    @(negedge clk);
    x_in = 7'h19; b_in = 7'h4E; k_in = 8'hC6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    x_in = 7'h63; b_in = 7'h05; k_in = 8'h9B; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    x_in = 7'h00; b_in = 7'h00; k_in = 8'h00;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("watchdog", 32'd0, 32'd1);
    cmp_pts("R9 busy start", 7'h19, 7'h4E, 8'hC6);
    @(negedge clk);
    chk("R10 done one cycle", 32'(done), 32'd0);
    repeat (30) @(negedge clk);
    chk("R10 no second done", 32'(done), 32'd0);
    cmp_pts("R10 hold", 7'h19, 7'h4E, 8'hC6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_scalar("R4 bits zero", 7'h35, 7'h01, 8'h80);
    t_scalar("R3 bits one", 7'h35, 7'h01, 8'hFF);
    t_scalar("R5 R6 mixed", 7'h4D, 7'h27, 8'hA5);
    t_scalar("R2 R7 mixed", 7'h01, 7'h7F, 8'hC3);
    for (int i = 0; i < 6; i++) begin
      logic [BM-1:0] xr = BM'((i * 37 + 11) % 128);
      logic [BM-1:0] br = BM'((i * 53 + 5) % 128);
      logic [BL-1:0] kr = BL'(((i * 97 + 29) % 128) | 128);
      t_scalar("R3 R4 R5 R6 random", xr, br, kr);
    end
    t_top_bit();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule